// File: doc/BRIEF.md
# Countdown and Timestamp Timer

This block is a small timer peripheral on a simple register bus. It has two channels. The event channel counts down from a value loaded by software. It raises a one-cycle interrupt pulse each time it expires, and it either stops after one expiry or reloads and runs again. The timestamp channel is a free-running 32-bit up-counter that software reads as a monotonic clock.

Both channels count on a tick chosen per channel in one shared control word. The base tick is nominally 1 µs and is made by dividing the input clock by `US_DIV`. The slow tick divides the base tick by `SLOW_DIV`. Writes take effect on the clock edge at which `bus_we` is high, and reads are combinational from `bus_addr`. The reset input is asynchronous and active-low, and a two-stage synchronizer releases it inside the block. `US_DIV` must be at least 2.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the event count, the timestamp count and `irq` are all zero.
- R2: The control word is at byte offset 0 and reads back the last written value ANDed with 0x0011_1703. That mask covers these fields: event timebase select in bits 1:0, timestamp timebase select in bits 10:8, event reload flag in bit 12, event enable in bit 16 and timestamp enable in bit 20.
- R3: With event enable and reload flag set, a load value N at offset 4 gives an `irq` pulse every (N+1) selected ticks.
- R4: With the reload flag clear, the event channel expires once, pulses `irq` once, and then holds a count of 0 (read at offset 4) until enable is cleared.
- R5: A write to offset 4 while event enable is clear only stores the value: no `irq` follows, and offset 4 reads back the stored value. Clearing enable stops counting and returns the readback to the stored value.
- R6: After enable is set, the first expiry comes N+1 ticks after counting starts from the stored value N.
- R7: Event timebase code 0 selects the base tick. Any other code selects the slow tick.
- R8: Timestamp code 1 selects the base tick, and the count at offset 20 rises by one per tick while timestamp enable is set.
- R9: Any timestamp code other than 1 selects the slow tick.
- R10: The timestamp count wraps from 0xFFFF_FFFF to 0. A write to offset 20 loads it, and it holds its value while disabled.
- R11: Each `irq` pulse is exactly one clock cycle wide.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Event channel expiry pulse |

## Verification
On every cycle, the assertions check the following: ticks never fall on two adjacent cycles, reserved control bits stay zero, a reloading expiry restores the stored value, and a one-shot expiry stops the count. They also check that `irq` never stays high for two cycles and that the timestamp either steps by exactly one on a tick or holds. Only the bench scenarios can show the actual periods in clock cycles for each timebase code, the latency from enable to first expiry, the silence after a write made while disabled, and the 32-bit wrap seen through bus reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W     = 32;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_EVT    = 4;   // (0+1)*4
  localparam int OFS_STAMP  = 20;  // (4+1)*4
  localparam int EVT_SEL_LSB   = 0;
  localparam int STAMP_SEL_LSB = 8;
  localparam int EVT_PER_BIT   = 12;
  localparam int EVT_EN_BIT    = 16;
  localparam int STAMP_EN_BIT  = 20;
  localparam logic [1:0] EVT_CODE_US   = 2'd0;
  localparam logic [2:0] STAMP_CODE_US = 3'd1;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0011_1703;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int US_DIV   = 24,
  parameter int SLOW_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick,
  output logic slow_tick
);
  localparam int UW = (US_DIV > 2) ? $clog2(US_DIV) : 1;
  localparam int SW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [UW-1:0] us_cnt_q, us_cnt_d;
  logic [SW-1:0] sl_cnt_q, sl_cnt_d;
  logic          us_wrap, sl_wrap;
  logic          us_tick_q, sl_tick_q;

  always_comb begin
    us_wrap  = (us_cnt_q == UW'(US_DIV - 1));
    sl_wrap  = us_wrap && (sl_cnt_q == SW'(SLOW_DIV - 1));
    us_cnt_d = us_wrap ? '0 : us_cnt_q + 1'b1;
    sl_cnt_d = sl_cnt_q;
    if (us_wrap) sl_cnt_d = sl_wrap ? '0 : sl_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt_q  <= '0;
      sl_cnt_q  <= '0;
      us_tick_q <= 1'b0;
      sl_tick_q <= 1'b0;
    end else begin
      us_cnt_q  <= us_cnt_d;
      sl_cnt_q  <= sl_cnt_d;
      us_tick_q <= us_wrap;
      sl_tick_q <= sl_wrap;
    end
  end

  assign us_tick   = us_tick_q;
  assign slow_tick = sl_tick_q;

  // Base tick never on adjacent cycles (needed for one-cycle irq, R11)
  p_tick_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    us_tick |=> !us_tick);
endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             periodic,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_pulse
);
  logic [CNT_W-1:0] load_q, cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             expire, irq_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    expire = 1'b0;
    if (!en) begin
      cnt_d  = load_q;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        if (periodic) cnt_d  = load_q;
        else          done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (load_we) load_q <= load_val;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      irq_q  <= expire;
    end
  end

  assign count        = cnt_q;
  assign expire_pulse = irq_q;

  p_irq_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic && !load_we) |=> (cnt_q == $past(load_q)));
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> done_q);
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && en) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_stamp_chan.sv
module tmr_stamp_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_we)          cnt_d = load_val;
    else if (en && tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  p_stamp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !load_we) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_stamp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 16,
  parameter int US_DIV   = 24,
  parameter int SLOW_DIV = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              sel_ctrl, sel_evt, sel_stamp;
  logic              us_tick, slow_tick, evt_tick, stamp_tick;
  logic              evt_en, evt_per, stamp_en;
  logic [CNT_W-1:0]  evt_count;
  logic [DATA_W-1:0] stamp_count;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    sel_evt   = (bus_addr == ADDR_W'(OFS_EVT));
    sel_stamp = (bus_addr == ADDR_W'(OFS_STAMP));
    ctrl_d    = (bus_we && sel_ctrl) ? (bus_wdata & CTRL_MASK) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  assign evt_en   = ctrl_q[EVT_EN_BIT];
  assign evt_per  = ctrl_q[EVT_PER_BIT];
  assign stamp_en = ctrl_q[STAMP_EN_BIT];
  assign evt_tick   = (ctrl_q[EVT_SEL_LSB +: 2] == EVT_CODE_US) ? us_tick : slow_tick;
  assign stamp_tick = (ctrl_q[STAMP_SEL_LSB +: 3] == STAMP_CODE_US) ? us_tick : slow_tick;

  tmr_tick_gen #(.US_DIV(US_DIV), .SLOW_DIV(SLOW_DIV)) i_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .us_tick   (us_tick),
    .slow_tick (slow_tick)
  );

  tmr_event_chan #(.CNT_W(CNT_W)) i_evt (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en           (evt_en),
    .periodic     (evt_per),
    .tick         (evt_tick),
    .load_we      (bus_we && sel_evt),
    .load_val     (bus_wdata[CNT_W-1:0]),
    .count        (evt_count),
    .expire_pulse (irq)
  );

  tmr_stamp_chan #(.W(DATA_W)) i_stamp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (stamp_en),
    .tick     (stamp_tick),
    .load_we  (bus_we && sel_stamp),
    .load_val (bus_wdata),
    .count    (stamp_count)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)       bus_rdata = ctrl_q;
    else if (sel_evt)   bus_rdata = DATA_W'(evt_count);
    else if (sel_stamp) bus_rdata = stamp_count;
  end

  p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int AW = 5;
  localparam int D  = 4;
  localparam int S  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  tick_timer #(.ADDR_W(AW), .CNT_W(16), .US_DIV(D), .SLOW_DIV(S)) i_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr);
    #1 data = bus_rdata;
  endtask

  // Cycles until irq seen high (limit on timeout)
  task automatic wait_irq(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < limit);
  endtask

  task automatic count_irq(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq) n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", 32'(irq), 0);
    rd(0, v);  check("R1 ctrl", v, 0);
    rd(4, v);  check("R1 evt", v, 0);
    rd(20, v); check("R1 stamp", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R2 mask", v, 32'h0011_1703);
    wr(0, 32'h0000_0000);
    rd(0, v); check("R2 clear", v, 0);
    rd(8, v); check("R12 unmapped", v, 0);
  endtask

  task automatic t_store_only;
    logic [31:0] v; int n;
    wr(4, 32'd5);
    count_irq(60, n); check("R5 no irq", 32'(n), 0);
    rd(4, v); check("R5 stored", v, 5);
  endtask

  task automatic t_periodic;
    logic [31:0] v; int n;
    wr(4, 32'd3);
    @(negedge clk); @(negedge clk);
    wr(0, 32'h0001_1000);
    wait_irq(200, n);
    checks++;
    if (n < 11 || n > 20) begin
      errors++; $display("FAIL R6: first expiry after %0d cycles, expected 11..20", n);
    end
    @(negedge clk); check("R11 width", 32'(irq), 0);
    wait_irq(200, n); check("R3 period", 32'(n + 1), 32'(4 * D));
    wait_irq(200, n); check("R3 period again", 32'(n), 32'(4 * D));
    wr(0, 32'h0);
    count_irq(60, n); check("R5 stop no irq", 32'(n), 0);
    rd(4, v); check("R5 stop readback", v, 3);
  endtask

  task automatic t_oneshot;
    logic [31:0] v; int n;
    wr(4, 32'd2);
    @(negedge clk);
    wr(0, 32'h0001_0000);
    wait_irq(200, n); check("R4 first irq", 32'(irq), 1);
    count_irq(100, n); check("R4 single", 32'(n), 0);
    rd(4, v); check("R4 held zero", v, 0);
    wr(0, 32'h0);
  endtask

  task automatic t_slow_evt;
    int n;
    wr(4, 32'd1);
    @(negedge clk);
    wr(0, 32'h0001_1002);
    wait_irq(300, n);
    wait_irq(300, n); check("R7 slow period", 32'(n), 32'(2 * D * S));
    wr(0, 32'h0);
  endtask

  task automatic t_stamp(input logic [31:0] ctl, input int win, input string req);
    logic [31:0] a, b;
    wr(0, ctl);
    rd(20, a);
    repeat (win - 1) @(negedge clk);
    rd(20, b);
    check(req, b - a, 10);
  endtask

  task automatic t_wrap;
    logic [31:0] a, b;
    wr(0, 32'h0);
    wr(20, 32'hFFFF_FFFE);
    repeat (20) @(negedge clk);
    rd(20, a); check("R10 hold while disabled", a, 32'hFFFF_FFFE);
    wr(0, 32'h0010_0100);
    rd(20, a);
    repeat (39) @(negedge clk);
    rd(20, b);
    check("R10 wrap step", b - a, 10);
    check("R10 wrapped low", 32'(b < 32'd16), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mask();
    t_store_only();
    t_periodic();
    t_oneshot();
    t_slow_evt();
    t_stamp(32'h0010_0100, 10 * D, "R8 base tick count");
    t_stamp(32'h0010_0200, 10 * D * S, "R9 slow tick count");
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule